// File: doc/BRIEF.md
# Column Line Latch with Alternating Drive Polarity

This block sits between a column data register and the analog back end of a display column driver. A full line of 6-bit gray codes, one per column, is presented in parallel. When the line strobe rises, the block copies the line into a holding latch and, in the same clock, samples the polarity input. From the latched line it produces one 8-bit drive descriptor per column. The descriptor says which reference bank the column takes its voltage from, which of the four interpolation segments of that bank applies, the step inside that segment, and whether the column output is floating.

Odd display columns use the bank chosen by the sampled polarity, and even columns use the other bank, so neighbouring columns always get opposite drive polarity. For each column, a 4-bit anchor also names the reference tap where the segment starts. The anchor rises with the code in the upper bank and falls with the code in the lower bank, because the lower bank is traversed in mirrored order. While the strobe is high, every column is marked floating. The newly latched levels are released when the strobe falls, and one strobe pulse is expected per line period.

The strobe and polarity inputs are plain level signals sampled on `clk`. There is no handshake and no back-pressure at any port. The line is taken whenever a rising strobe is seen, and the descriptors are continuous outputs.

Top module: `lcd_line_latch`

## Requirements
- R1: After reset every column is floating (descriptor bit 7 = 1), the latched line is all code 00h and the sampled polarity is low. Outputs keep this state, whatever `line_data` does, until a strobe pulse has risen and fallen.
- R2: At the first clock edge where `strobe` is sampled high after being sampled low, the whole of `line_data` is latched. Changes on `line_data` at any other time, with the strobe either high or low, do not change the outputs.
- R3: From the clock edge that detects the strobe rise, and for as long as `strobe` is sampled high, every column's descriptor bit 7 is 1.
- R4: At the first clock edge where `strobe` is sampled low after being high, bit 7 of every column drops to 0. The descriptors then show the line latched at the preceding rise.
- R5: `polarity` is sampled only at the edge that detects the strobe rise. A change at any other time has no effect on the outputs.
- R6: Column k (0-based; k even is an odd display column) has bank bit 6 equal to the sampled polarity when k is even, and to its inverse when k is odd. Bank 0 is the upper bank (references 0 to 4) and bank 1 is the lower bank (references 5 to 9).
- R7: Bits [5:4] of the descriptor give the segment, equal to code[5:4], and bits [3:0] give the step, equal to code[3:0], in both banks. Codes 00h, 10h, 20h and 30h therefore land on step 0 of segments 0 to 3, and code 3Fh gives segment 3, step 15, which is the end tap of a 15-step top segment.
- R8: The anchor of column k equals the segment in bank 0 (taps 0 to 3). In bank 1 it equals 9 minus the segment (taps 9 down to 6), so code 00h starts at reference 9 and codes 30h to 3Fh run from reference 6 toward reference 5.
- R9: Column k's code is `line_data[6k+5:6k]`, its descriptor is `col_desc[8k+7:8k]`, and its anchor is `col_anchor[4k+3:4k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which strobe and polarity are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_data | input | NCOL*6 | Gray codes for the whole line, column 0 in the low bits |
| strobe | input | 1 | Line strobe: the rise latches the line, high forces floating, the fall releases the line |
| polarity | input | 1 | Drive polarity for the next line, sampled at the strobe rise |
| col_desc | output | NCOL*8 | Per-column {floating, bank, segment[1:0], step[3:0]} |
| col_anchor | output | NCOL*4 | Per-column reference tap where the segment starts |

## Verification
A corrupted latch or a stale polarity flop shows on every column's descriptor one clock after the strobe rise, while the columns are still floating, so it is caught before the line is ever released. A floating flag that fails to set or clear appears on bit 7 of every column in the clock after the strobe edge concerned. A swapped bank or an unmirrored anchor shows only on the columns of one parity or one bank. For that reason, every column is compared on lines that mix both polarities with tap codes, the top code and random codes.

// File: rtl/lcd_latch_pkg.sv
`timescale 1ns/1ps
package lcd_latch_pkg;
  localparam int CODE_W = 6;
  localparam int SEG_W  = 2;
  localparam int STEP_W = CODE_W - SEG_W;
  localparam int TAP_W  = 4;
  localparam int DESC_W = 2 + SEG_W + STEP_W;

  // Tap index of the far end of the lower bank (its code-00h tap)
  localparam logic [TAP_W-1:0] LOWER_BASE_TAP = TAP_W'(9);

  typedef enum logic {
    BANK_UPPER = 1'b0,
    BANK_LOWER = 1'b1
  } bank_e;

  typedef struct packed {
    logic              hiz;
    bank_e             bank;
    logic [SEG_W-1:0]  seg;
    logic [STEP_W-1:0] step;
  } col_desc_t;
endpackage

// File: rtl/lcd_strobe_ctl.sv
`timescale 1ns/1ps
module lcd_strobe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic polarity,
  output logic capture,
  output logic hiz,
  output logic pol_q
);
  logic stb_q;
  logic release_line;

  assign capture      = strobe & ~stb_q;
  assign release_line = ~strobe & stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      hiz   <= 1'b1;
      pol_q <= 1'b0;
    end else begin
      stb_q <= strobe;
      if (capture) begin
        hiz   <= 1'b1;
        pol_q <= polarity;
      end else if (release_line) begin
        hiz   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcd_line_store.sv
`timescale 1ns/1ps
module lcd_line_store #(
  parameter int NCOL   = 480,
  parameter int CODE_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NCOL*CODE_W-1:0] line_in,
  output logic [NCOL*CODE_W-1:0] line_q
);
  for (genvar k = 0; k < NCOL; k++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[k*CODE_W +: CODE_W] <= '0;
      end else if (load) begin
        line_q[k*CODE_W +: CODE_W] <= line_in[k*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/lcd_col_encoder.sv
`timescale 1ns/1ps
module lcd_col_encoder
  import lcd_latch_pkg::*;
#(
  parameter bit ODD_COL = 1'b1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              pol,
  input  logic              hiz,
  output col_desc_t         desc,
  output logic [TAP_W-1:0]  anchor
);
  bank_e            bank;
  logic [SEG_W-1:0] seg;

  if (ODD_COL) begin : g_odd
    assign bank = pol ? BANK_LOWER : BANK_UPPER;
  end else begin : g_even
    assign bank = pol ? BANK_UPPER : BANK_LOWER;
  end

  assign seg = code[CODE_W-1 -: SEG_W];

  always_comb begin
    desc.hiz  = hiz;
    desc.bank = bank;
    desc.seg  = seg;
    desc.step = code[STEP_W-1:0];
    if (bank == BANK_LOWER) begin
      anchor = LOWER_BASE_TAP - TAP_W'(seg);
    end else begin
      anchor = TAP_W'(seg);
    end
  end
endmodule

// File: rtl/lcd_line_latch.sv
`timescale 1ns/1ps
module lcd_line_latch
  import lcd_latch_pkg::*;
#(
  parameter int NCOL = 480
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCOL*CODE_W-1:0] line_data,
  input  logic                   strobe,
  input  logic                   polarity,
  output logic [NCOL*DESC_W-1:0] col_desc,
  output logic [NCOL*TAP_W-1:0]  col_anchor
);
  logic                   capture;
  logic                   hiz;
  logic                   pol_q;
  logic [NCOL*CODE_W-1:0] line_q;

  lcd_strobe_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .polarity (polarity),
    .capture  (capture),
    .hiz      (hiz),
    .pol_q    (pol_q)
  );

  lcd_line_store #(.NCOL(NCOL), .CODE_W(CODE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (capture),
    .line_in (line_data),
    .line_q  (line_q)
  );

  for (genvar k = 0; k < NCOL; k++) begin : g_enc
    col_desc_t d;
    lcd_col_encoder #(.ODD_COL((k % 2) == 0)) u_enc (
      .code   (line_q[k*CODE_W +: CODE_W]),
      .pol    (pol_q),
      .hiz    (hiz),
      .desc   (d),
      .anchor (col_anchor[k*TAP_W +: TAP_W])
    );
    assign col_desc[k*DESC_W +: DESC_W] = d;
  end
endmodule

// File: rtl/lcd_line_latch_chk.sv
`timescale 1ns/1ps
module lcd_line_latch_chk #(
  parameter int NCOL = 480
) (
  input logic                clk,
  input logic                rst_n,
  input logic                strobe,
  input logic [NCOL*8-1:0]   col_desc,
  input logic [NCOL*4-1:0]   col_anchor
);
  logic [7:0] d0, d1, dl;
  logic [3:0] a0;
  assign d0 = col_desc[7:0];
  assign d1 = col_desc[15:8];
  assign dl = col_desc[NCOL*8-1 -: 8];
  assign a0 = col_anchor[3:0];

  // R3
  hiz_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (d0[7] && dl[7]));

  // R4
  release_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(d0[7]) |-> !$past(strobe));

  // R2
  hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(d0[6:0]) && $stable(dl[6:0]) && $stable(a0)));

  // R6
  adjacent_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d0[6] != d1[6]);

  // R8
  anchor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d0[6] ? (a0 >= 4'd6 && a0 <= 4'd9) : (a0 <= 4'd3));
endmodule

bind lcd_line_latch lcd_line_latch_chk #(.NCOL(NCOL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe     (strobe),
  .col_desc   (col_desc),
  .col_anchor (col_anchor)
);

// File: tb/tb_lcd_line_latch.sv
`timescale 1ns/1ps
module tb_lcd_line_latch;
  localparam int NCOL = 480;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCOL*6-1:0] line_data = '0;
  logic              strobe = 1'b0;
  logic              polarity = 1'b0;
  logic [NCOL*8-1:0] col_desc;
  logic [NCOL*4-1:0] col_anchor;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] exp_code [NCOL];
  logic       exp_pol = 1'b0;

  always #4 clk = ~clk;

  lcd_line_latch #(.NCOL(NCOL)) dut (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .strobe(strobe),
    .polarity(polarity), .col_desc(col_desc), .col_anchor(col_anchor)
  );

  function automatic logic [7:0] want_desc(logic [5:0] c, int k, logic p, logic h);
    logic bank;
    bank = ((k % 2) == 0) ? p : ~p;   // R6
    return {h, bank, c[5:4], c[3:0]}; // R7, R9
  endfunction

  function automatic logic [3:0] want_anchor(logic [5:0] c, int k, logic p);
    logic bank;
    bank = ((k % 2) == 0) ? p : ~p;
    return bank ? (4'd9 - {2'b00, c[5:4]}) : {2'b00, c[5:4]}; // R8
  endfunction

  task automatic check_all(logic h, string req);
    for (int k = 0; k < NCOL; k++) begin
      logic [7:0] gd, ed;
      logic [3:0] ga, ea;
      gd = col_desc[k*8 +: 8];
      ga = col_anchor[k*4 +: 4];
      ed = want_desc(exp_code[k], k, exp_pol, h);
      ea = want_anchor(exp_code[k], k, exp_pol);
      checks++;
      if (gd !== ed || ga !== ea) begin
        errors++;
        $display("FAIL %s col %0d desc got %h exp %h anchor got %0d exp %0d",
                 req, k, gd, ed, ga, ea);
      end
    end
  endtask

  task automatic scramble_inputs();
    for (int k = 0; k < NCOL; k++) line_data[k*6 +: 6] = 6'($urandom_range(0, 63));
    polarity = ~polarity;
  endtask

  // pattern: 0 random, 1 taps and top code, 2 all 3Fh, 3 all 00h, 4 ramp
  task automatic run_line(int pattern, logic p, int high_cycles);
    @(negedge clk);
    for (int k = 0; k < NCOL; k++) begin
      logic [5:0] c;
      case (pattern)
        1: begin
          case (k % 5)
            0: c = 6'h00;
            1: c = 6'h10;
            2: c = 6'h20;
            3: c = 6'h30;
            default: c = 6'h3F;
          endcase
        end
        2: c = 6'h3F;
        3: c = 6'h00;
        4: c = 6'(k % 64);
        default: c = 6'($urandom_range(0, 63));
      endcase
      exp_code[k] = c;
      line_data[k*6 +: 6] = c;
    end
    polarity = p;
    exp_pol  = p;
    strobe   = 1'b1;
    @(negedge clk);
    check_all(1'b1, "R2_R3_R6");
    // data and polarity moving while the strobe is high must be ignored
    scramble_inputs();
    for (int i = 0; i < high_cycles; i++) @(negedge clk);
    check_all(1'b1, "R3_R5");
    strobe = 1'b0;
    @(negedge clk);
    check_all(1'b0, "R4_R7_R8");
    // moving inputs while the strobe is low must be ignored
    scramble_inputs();
    repeat (3) @(negedge clk);
    check_all(1'b0, "R2_R5");
  endtask

  initial begin
    void'($urandom(32'h5EED_0421));
    for (int k = 0; k < NCOL; k++) exp_code[k] = 6'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(1'b1, "R1");
    // inputs moving before any strobe leave the reset state alone (R1)
    scramble_inputs();
    repeat (2) @(negedge clk);
    check_all(1'b1, "R1");

    run_line(1, 1'b0, 1);  // R7 taps, R8 mirrored anchors
    run_line(1, 1'b1, 2);  // R6 swapped banks
    run_line(2, 1'b0, 1);  // R7 top code
    run_line(2, 1'b1, 3);
    run_line(3, 1'b1, 1);
    run_line(4, 1'b0, 2);
    for (int n = 0; n < 12; n++) begin
      run_line(0, 1'($urandom_range(0, 1)), 1 + $urandom_range(0, 3));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule